// File: doc/BRIEF.md
# Flash Page Latch Buffer

This block holds one page of data that is staged before a non-volatile page is programmed. A bus master writes 32-bit words anywhere in the flash address window. Only the in-page word offset, taken from the low address bits, picks the slot, so the page image appears again and again across the whole window. A programming engine reads the staged page one word at a time through a separate read port.

Writes must form an unbroken run of adjacent words in a single direction. The run may climb or fall, and it wraps at the page edge. A byte or half-word write is refused and raises a sticky size flag. A write that breaks the run is refused and raises a sticky order flag. Both flags clear when the next command starts. Each write is held off by the same number of wait states that is configured for flash reads. When the engine reports that a command has finished, every word is refilled with ones and run tracking starts over. The contents after power-up are not defined.

Top module: `flash_page_latch`

## Requirements
- R1: An accepted 32-bit write (`wr_size` = 2'b10) that is in order stores `wr_data` in word slot `wr_addr[IDX_W+1:2]`. Higher address bits are ignored, so the page aliases across the window.
- R2: A write with `wr_size` of 2'b00 (byte), 2'b01 (half-word) or 2'b11 is not stored and sets `err_size` on the accepting edge.
- R3: The first word write after reset or after a finished command is always stored and starts a run. The second write must land one slot above or one slot below the first, and that choice fixes the direction of the run.
- R4: Once a direction is fixed, each word write must land one slot further in that direction. Any other write is not stored, sets `err_order`, and leaves the run position unchanged.
- R5: Slot indices wrap modulo WORDS. Slot WORDS-1 is followed by slot 0 going up, and slot 0 is followed by slot WORDS-1 going down.
- R6: `wr_ready` rises only while `wr_req` is held. It rises in the cycle in which the request has waited `wait_cfg` cycles, which means at once when `wait_cfg` is 0.
- R7: A `cmd_done` pulse sets every slot to all ones by the next cycle and clears the run state. A write accepted in the same cycle is dropped.
- R8: `err_size` and `err_order` stay set until a `cmd_start` pulse, which clears both on the next edge. Both are 0 after reset.
- R9: `rd_word` shows the contents of slot `rd_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the control state |
| wr_req | input | 1 | Write request, held until `wr_ready` |
| wr_addr | input | ADDR_W | Byte address in the flash window |
| wr_size | input | 2 | Access size: 00 byte, 01 half-word, 10 word |
| wr_data | input | 32 | Write data |
| wait_cfg | input | WS_W | Wait states of a flash read |
| wr_ready | output | 1 | Write accepted in this cycle |
| cmd_start | input | 1 | Pulse: a programming command starts |
| cmd_done | input | 1 | Pulse: a programming command has finished |
| err_size | output | 1 | Sticky sub-word write flag |
| err_order | output | 1 | Sticky ordering violation flag |
| rd_idx | input | IDX_W | Page slot read by the engine |
| rd_word | output | 32 | Contents of slot `rd_idx` |

## Verification
The checker checks the following on every cycle. A ready only appears under a held request, and only after a waiting request when wait states are configured. A refused sub-word access always raises its flag. Both flags are sticky and are cleared by a command start. The page reads all ones one cycle after a command finishes. The following can only be shown by the bench's scenarios, which read back through the page port. Aliasing of high address bits. Which writes are stored and which are refused. How the direction is picked from the second write. Wrapping at both page edges. The exact number of wait cycles.

// File: rtl/flash_page_latch.sv
module flash_page_latch #(
  parameter int WORDS  = 128,
  parameter int ADDR_W = 20,
  parameter int WS_W   = 4,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_size,
  input  logic [31:0]       wr_data,
  input  logic [WS_W-1:0]   wait_cfg,
  output logic              wr_ready,
  input  logic              cmd_start,
  input  logic              cmd_done,
  output logic              err_size,
  output logic              err_order,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [31:0]       rd_word
);

  logic [31:0]      page [WORDS];
  logic [WS_W-1:0]  wcnt;
  logic             run_on, dir_set, dir_up;
  logic [IDX_W-1:0] last_idx;

  wire [IDX_W-1:0] idx     = wr_addr[IDX_W+1:2];
  wire [IDX_W-1:0] idx_up  = last_idx + 1'b1;
  wire [IDX_W-1:0] idx_dn  = last_idx - 1'b1;
  wire             is_word = (wr_size == 2'b10);
  wire             in_order = !run_on ||
                     (dir_set ? (dir_up ? idx == idx_up : idx == idx_dn)
                              : (idx == idx_up || idx == idx_dn));
  wire             store   = wr_ready && is_word && in_order && !cmd_done;

  assign wr_ready = wr_req && (wcnt == wait_cfg);
  assign rd_word  = page[rd_idx];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wcnt <= '0;
    else        wcnt <= (wr_req && !wr_ready) ? wcnt + 1'b1 : '0;

  always_ff @(posedge clk)
    for (int i = 0; i < WORDS; i++)
      if (cmd_done) page[i] <= '1;
      else if (store && idx == IDX_W'(i)) page[i] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run_on   <= 1'b0;
      dir_set  <= 1'b0;
      dir_up   <= 1'b0;
      last_idx <= '0;
    end else if (cmd_done) begin
      run_on  <= 1'b0;
      dir_set <= 1'b0;
    end else if (store) begin
      run_on   <= 1'b1;
      last_idx <= idx;
      if (run_on && !dir_set) begin
        dir_set <= 1'b1;
        dir_up  <= (idx == idx_up);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      err_size  <= 1'b0;
      err_order <= 1'b0;
    end else if (cmd_start) begin
      err_size  <= 1'b0;
      err_order <= 1'b0;
    end else if (wr_ready && !cmd_done) begin
      if (!is_word) err_size <= 1'b1;
      else if (!in_order) err_order <= 1'b1;
    end

endmodule

// File: rtl/flash_page_latch_chk.sv
module flash_page_latch_chk #(
  parameter int WS_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_req,
  input logic [1:0]      wr_size,
  input logic [WS_W-1:0] wait_cfg,
  input logic            wr_ready,
  input logic            cmd_start,
  input logic            cmd_done,
  input logic            err_size,
  input logic            err_order,
  input logic [31:0]     rd_word
);

  a_r6_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> wr_req);

  a_r6_wait_honoured: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && wait_cfg != '0) |-> $past(wr_req));

  a_r2_subword_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && wr_size != 2'b10 && !cmd_start && !cmd_done) |=> err_size);

  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> (!err_size && !err_order));

  a_r8_size_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_size && !cmd_start) |=> err_size);

  a_r8_order_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_order && !cmd_start) |=> err_order);

  a_r7_refill_ones: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> (rd_word == 32'hFFFF_FFFF));

endmodule

bind flash_page_latch flash_page_latch_chk #(.WS_W(WS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_size(wr_size),
  .wait_cfg(wait_cfg), .wr_ready(wr_ready), .cmd_start(cmd_start),
  .cmd_done(cmd_done), .err_size(err_size), .err_order(err_order),
  .rd_word(rd_word)
);

// File: tb/sim_flash_page_latch.sv
module sim_flash_page_latch;
  localparam int WORDS = 128, ADDR_W = 20, WS_W = 4, IDX_W = 7;
  localparam int HI_W = ADDR_W - IDX_W - 2;

  logic clk = 0, rst_n = 0;
  logic wr_req = 0, cmd_start = 0, cmd_done = 0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [1:0] wr_size = 2'b10;
  logic [31:0] wr_data = '0;
  logic [WS_W-1:0] wait_cfg = '0;
  logic [IDX_W-1:0] rd_idx = '0;
  logic wr_ready, err_size, err_order;
  logic [31:0] rd_word;
  int checks = 0, fails = 0;
  logic [31:0] model [WORDS];

  always #2.5 clk = ~clk;

  flash_page_latch #(.WORDS(WORDS), .ADDR_W(ADDR_W), .WS_W(WS_W)) u0 (.*);

  // size, slot, alias high bits, data, stored, exp err_size, exp err_order
  localparam int VN = 8;
  localparam logic [2+IDX_W+HI_W+32+3-1:0] VEC [VN] = '{
    {2'b10, 7'd5,   11'd0,   32'hA5A5_0005, 1'b1, 1'b0, 1'b0},
    {2'b10, 7'd6,   11'd3,   32'hA5A5_0006, 1'b1, 1'b0, 1'b0},
    {2'b01, 7'd7,   11'd0,   32'h1111_2222, 1'b0, 1'b1, 1'b0},
    {2'b10, 7'd7,   11'd900, 32'hA5A5_0007, 1'b1, 1'b1, 1'b0},
    {2'b10, 7'd5,   11'd0,   32'hDEAD_0005, 1'b0, 1'b1, 1'b1},
    {2'b00, 7'd8,   11'd1,   32'h0000_00FF, 1'b0, 1'b1, 1'b1},
    {2'b10, 7'd8,   11'd2047,32'hA5A5_0008, 1'b1, 1'b1, 1'b1},
    {2'b10, 7'd9,   11'd17,  32'hA5A5_0009, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] sz, input logic [IDX_W-1:0] slot,
                        input logic [HI_W-1:0] hi, input logic [31:0] d, output int waited);
    wr_req = 1; wr_size = sz; wr_addr = {hi, slot, 2'b00}; wr_data = d;
    waited = 0;
    #1;
    while (!wr_ready) begin
      @(posedge clk); #1; waited++;
    end
    @(posedge clk); #1;
    wr_req = 0;
  endtask

  task automatic command();
    cmd_start = 1; @(posedge clk); #1; cmd_start = 0;
    repeat (2) @(posedge clk); #1;
    cmd_done = 1; @(posedge clk); #1; cmd_done = 0;
    for (int i = 0; i < WORDS; i++) model[i] = '1;
  endtask

  task automatic rd(input string req, input int slot, input logic [31:0] exp);
    rd_idx = IDX_W'(slot); #0.5;
    chk(req, rd_word, exp);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int w;
    @(posedge clk); #1;
    chk("R8 reset err_size", {31'b0, err_size}, 0);
    chk("R8 reset err_order", {31'b0, err_order}, 0);
    chk("R6 reset ready", {31'b0, wr_ready}, 0);
    rst_n = 1;
    @(posedge clk); #1;
    command();
    rd("R7 refill slot 0", 0, 32'hFFFF_FFFF);
    rd("R7 refill slot 127", 127, 32'hFFFF_FFFF);

    wait_cfg = 4'd1;
    for (int v = 0; v < VN; v++) begin
      logic [1:0] sz; logic [IDX_W-1:0] sl; logic [HI_W-1:0] hi; logic [31:0] d;
      logic st, es, eo;
      {sz, sl, hi, d, st, es, eo} = VEC[v];
      bus_wr(sz, sl, hi, d, w);
      if (st) model[sl] = d;
      chk("R2 err_size", {31'b0, err_size}, {31'b0, es});
      chk("R4 err_order", {31'b0, err_order}, {31'b0, eo});
      rd("R1 slot contents", int'(sl), model[sl]);
    end
    rd("R1 slot 5 kept", 5, 32'hA5A5_0005);

    cmd_start = 1; @(posedge clk); #1; cmd_start = 0;
    chk("R8 start clears size", {31'b0, err_size}, 0);
    chk("R8 start clears order", {31'b0, err_order}, 0);

    for (int c = 0; c < 4; c++) begin
      wait_cfg = WS_W'(c * 3);
      bus_wr(2'b10, 7'd9 + 7'(c), 11'd0, 32'h5000_0000 + c, w);
      chk("R6 wait cycles", w, c * 3);
    end

    command();
    wait_cfg = 0;
    bus_wr(2'b10, 7'd1, 11'd4, 32'hB000_0001, w);
    bus_wr(2'b10, 7'd0, 11'd0, 32'hB000_0000, w);
    bus_wr(2'b10, 7'd127, 11'd5, 32'hB000_007F, w);
    bus_wr(2'b10, 7'd126, 11'd0, 32'hB000_007E, w);
    rd("R5 descending wrap 127", 127, 32'hB000_007F);
    rd("R5 descending wrap 126", 126, 32'hB000_007E);
    rd("R3 first of run", 1, 32'hB000_0001);
    chk("R4 no error on descent", {31'b0, err_order}, 0);
    bus_wr(2'b10, 7'd127, 11'd0, 32'hBAD0_0000, w);
    chk("R4 reversal flagged", {31'b0, err_order}, 1);
    rd("R4 reversal not stored", 127, 32'hB000_007F);
    bus_wr(2'b10, 7'd125, 11'd0, 32'hB000_007D, w);
    rd("R4 run position kept", 125, 32'hB000_007D);

    command();
    chk("R8 command clears order", {31'b0, err_order}, 0);
    rd("R7 refill after run", 126, 32'hFFFF_FFFF);
    bus_wr(2'b10, 7'd126, 11'd0, 32'hC000_007E, w);
    bus_wr(2'b10, 7'd20, 11'd0, 32'hBAD0_0014, w);
    chk("R3 non-adjacent second flagged", {31'b0, err_order}, 1);
    rd("R3 non-adjacent not stored", 20, 32'hFFFF_FFFF);
    bus_wr(2'b10, 7'd127, 11'd0, 32'hC000_007F, w);
    bus_wr(2'b10, 7'd0, 11'd0, 32'hC000_0000, w);
    rd("R5 ascending wrap 0", 0, 32'hC000_0000);
    rd("R3 ascending second", 127, 32'hC000_007F);

    cmd_start = 1; @(posedge clk); #1; cmd_start = 0;
    wr_req = 1; wr_size = 2'b10; wr_addr = {11'd0, 7'd1, 2'b00}; wr_data = 32'hBAD0_0001;
    cmd_done = 1; #1;
    @(posedge clk); #1; wr_req = 0; cmd_done = 0;
    rd("R7 collided write dropped", 1, 32'hFFFF_FFFF);
    bus_wr(2'b10, 7'd50, 11'd0, 32'hD000_0032, w);
    rd("R7 run restarted", 50, 32'hD000_0032);
    chk("R7 restart no error", {31'b0, err_order}, 0);
    rd("R9 read port other slot", 0, 32'hFFFF_FFFF);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule